// File: doc/BRIEF.md
# Tolerance-Band Arm Level Modulator

This block decides how many series cells of one converter arm are switched into the current path. On every sample tick it adds the voltage the arm is producing, minus the reference voltage, to a signed accumulator. The accumulated value is the volt-second error of the arm.

The arm voltage is the present level count times the capacitor voltage of one cell. When the accumulated error leaves a symmetric window of programmable half-width, the block steps the level count by one. Below the window it adds a level, and above the window it removes one.

A wider window gives fewer steps but a larger ripple in the synthesized voltage. The scheme suits arms with only a handful of cells. Which physical cell is switched is decided elsewhere.

Top module: `tband_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, `level` becomes 0, `flux_err` becomes 0, and `step_up` and `step_dn` become 0.
- R2: On an edge with `tick` high, `flux_err` takes the value `flux_err + level*v_cap - v_ref`. Every operand is taken before that edge, and the voltages are unsigned. The new value is visible after that edge.
- R3: On a tick, if the updated error is strictly below `-band` and `level` is below `N`, then `level` rises by one and `step_up` is 1 for exactly that one cycle.
- R4: On a tick, if the updated error is strictly above `+band` and `level` is above 0, then `level` falls by one and `step_dn` is 1 for exactly that one cycle.
- R5: On a tick whose updated error lies within `[-band, +band]`, both ends included, `level` is unchanged and neither step output pulses.
- R6: A request to add a level while `level` equals `N` has no effect, and neither has a request to remove a level while `level` is 0. In both cases `level` holds and no step pulse is produced.
- R7: On an edge with `tick` low, `level` and `flux_err` hold, and both step outputs are 0.
- R8: `step_up` and `step_dn` are never high together, and `level` changes by at most one per cycle.
- R9: `level` never exceeds `N` (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe; one integration step per high cycle |
| v_ref | input | VW (16) | Reference arm voltage, unsigned |
| v_cap | input | VW (16) | Capacitor voltage of one cell, unsigned |
| band | input | BW (16) | Half-width of the error window, unsigned |
| level | output | LW (4) | Number of cells inserted, 0..N |
| flux_err | output | IW (32) | Accumulated volt-second error, signed two's complement |
| step_up | output | 1 | One-cycle pulse: a level was added |
| step_dn | output | 1 | One-cycle pulse: a level was removed |

## Verification
Every output is a register that is loaded at the same edge that samples `tick` and its operands. The new error, the new level and the step pulse are therefore all due one cycle after a tick is presented.

The bench drives each input set on a falling edge and updates its own model for that set. It then compares all four outputs on the following falling edge, half a period after the loading edge.

Directed runs cover the inclusive window edge and both saturation limits. Random runs then vary the reference, the cell voltage, the window width and the gaps between ticks.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int FLUX_W = 32;
  typedef logic signed [FLUX_W-1:0] flux_t;

  function automatic int lvl_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tbm_integrator.sv
module tbm_integrator #(
  parameter int VW = 16,
  parameter int LW = 4,
  parameter int IW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [LW-1:0]        level,
  input  logic [VW-1:0]        v_ref,
  input  logic [VW-1:0]        v_cap,
  output logic signed [IW-1:0] acc,
  output logic signed [IW-1:0] acc_next
);
  localparam int PW = LW + VW;

  logic [PW-1:0]        prod;
  logic signed [IW-1:0] act_s;
  logic signed [IW-1:0] ref_s;

  assign prod     = {{VW{1'b0}}, level} * {{LW{1'b0}}, v_cap};
  assign act_s    = IW'(prod);
  assign ref_s    = IW'(v_ref);
  assign acc_next = acc + act_s - ref_s;

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (tick) acc <= acc_next;
  end
endmodule

// File: rtl/tbm_band_cmp.sv
module tbm_band_cmp #(
  parameter int BW = 16,
  parameter int IW = 32
) (
  input  logic                 tick,
  input  logic signed [IW-1:0] err,
  input  logic [BW-1:0]        band,
  output logic                 want_up,
  output logic                 want_dn
);
  logic signed [IW-1:0] lim;

  assign lim = IW'(band);

  always_comb begin
    want_up = tick && (err < -lim);
    want_dn = tick && (err > lim);
  end
endmodule

// File: rtl/tbm_level_ctr.sv
module tbm_level_ctr #(
  parameter int N  = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          want_up,
  input  logic          want_dn,
  output logic [LW-1:0] level,
  output logic          step_up,
  output logic          step_dn
);
  localparam logic [LW-1:0] TOP = LW'(N);

  logic can_up;
  logic can_dn;

  assign can_up = want_up && (level != TOP);
  assign can_dn = want_dn && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= '0;
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= can_up;
      step_dn <= can_dn && !can_up;
      if (can_up)      level <= level + 1'b1;
      else if (can_dn) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/tband_modulator.sv
module tband_modulator #(
  parameter int N  = 8,
  parameter int VW = 16,
  parameter int BW = 16,
  parameter int IW = tbm_pkg::FLUX_W,
  parameter int LW = tbm_pkg::lvl_width(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [VW-1:0]        v_ref,
  input  logic [VW-1:0]        v_cap,
  input  logic [BW-1:0]        band,
  output logic [LW-1:0]        level,
  output logic signed [IW-1:0] flux_err,
  output logic                 step_up,
  output logic                 step_dn
);
  logic signed [IW-1:0] err_next;
  logic                 want_up;
  logic                 want_dn;

  tbm_integrator #(.VW(VW), .LW(LW), .IW(IW)) integ_i (
    .clk(clk), .rst(rst), .tick(tick), .level(level),
    .v_ref(v_ref), .v_cap(v_cap), .acc(flux_err), .acc_next(err_next)
  );

  tbm_band_cmp #(.BW(BW), .IW(IW)) cmp_i (
    .tick(tick), .err(err_next), .band(band),
    .want_up(want_up), .want_dn(want_dn)
  );

  tbm_level_ctr #(.N(N), .LW(LW)) ctr_i (
    .clk(clk), .rst(rst), .want_up(want_up), .want_dn(want_dn),
    .level(level), .step_up(step_up), .step_dn(step_dn)
  );
endmodule

// File: rtl/tbm_checker.sv
module tbm_checker #(
  parameter int N  = 8,
  parameter int LW = 4,
  parameter int IW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic [LW-1:0]        level,
  input logic signed [IW-1:0] flux_err,
  input logic                 step_up,
  input logic                 step_dn
);
  a_r8_one_step: assert property (@(posedge clk) disable iff (rst)
    !(step_up && step_dn));

  a_r9_level_max: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(N));

  a_r3_up_adds_one: assert property (@(posedge clk) disable iff (rst)
    step_up |-> (level == $past(level) + 1'b1));

  a_r4_dn_drops_one: assert property (@(posedge clk) disable iff (rst)
    step_dn |-> (level == $past(level) - 1'b1));

  a_r6_top_blocks_up: assert property (@(posedge clk) disable iff (rst)
    (level == LW'(N)) |=> !step_up);

  a_r6_floor_blocks_dn: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !step_dn);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(level) && $stable(flux_err) && !step_up && !step_dn));

  a_r8_no_silent_change: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |-> $stable(level));
endmodule

bind tband_modulator tbm_checker #(.N(N), .LW(LW), .IW(IW)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .level(level),
  .flux_err(flux_err), .step_up(step_up), .step_dn(step_dn)
);

// File: tb/tband_modulator_tb_top.sv
module tband_modulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int VW = 16;
  localparam int BW = 16;
  localparam int IW = 32;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [VW-1:0] v_ref = '0;
  logic [VW-1:0] v_cap = '0;
  logic [BW-1:0] band = '0;
  logic [LW-1:0]        level;
  logic signed [IW-1:0] flux_err;
  logic                 step_up;
  logic                 step_dn;

  int     total = 0;
  int     bad = 0;
  int     m_lvl = 0;
  longint m_flux = 0;
  bit     m_up = 1'b0;
  bit     m_dn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tband_modulator #(.N(N), .VW(VW), .BW(BW), .IW(IW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .v_ref(v_ref), .v_cap(v_cap),
    .band(band), .level(level), .flux_err(flux_err),
    .step_up(step_up), .step_dn(step_dn)
  );

  // Compares all outputs with the model; R8 and R9 apply to every check.
  task automatic check_out(input string tag);
    logic signed [IW-1:0] ef;
    ef = IW'(m_flux);
    total++;
    if (level !== LW'(m_lvl) || flux_err !== ef || step_up !== m_up ||
        step_dn !== m_dn || (step_up && step_dn) || level > LW'(N)) begin
      bad++;
      $display("FAIL %s (R2 R8 R9 also): level=%0d flux=%0d up=%0b dn=%0b expected level=%0d flux=%0d up=%0b dn=%0b",
               tag, level, flux_err, step_up, step_dn, m_lvl, ef, m_up, m_dn);
    end
  endtask

  // Called at a falling edge: drives one input set, updates the model, checks next falling edge.
  task automatic drive(input bit t, input int r, input int c, input int b);
    string tag;
    longint nx;
    tick = t; v_ref = VW'(r); v_cap = VW'(c); band = BW'(b);
    m_up = 1'b0; m_dn = 1'b0;
    tag = "R7";
    if (t) begin
      nx = m_flux + longint'(m_lvl) * c - r;
      if (nx < -b) begin
        if (m_lvl < N) begin m_lvl++; m_up = 1'b1; tag = "R3"; end
        else tag = "R6";
      end else if (nx > b) begin
        if (m_lvl > 0) begin m_lvl--; m_dn = 1'b1; tag = "R4"; end
        else tag = "R6";
      end else tag = "R5";
      m_flux = nx;
    end
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0;
    repeat (3) @(negedge clk);
    m_lvl = 0; m_flux = 0; m_up = 1'b0; m_dn = 1'b0;
    check_out("R1");
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R5: error exactly at -band stays inside the window; one more unit steps up (R3)
    drive(1'b1, 100, 100, 100);
    drive(1'b1, 1, 100, 100);
    drive(1'b0, 0, 100, 100);
    do_reset();
    // climb to the top limit, then R6 holds at N
    for (int i = 0; i < 12; i++) drive(1'b1, 800, 100, 0);
    // fall back to the floor, then R6 holds at 0
    for (int i = 0; i < 25; i++) drive(1'b1, 0, 100, 0);
    // random mix with idle gaps (R7)
    for (int i = 0; i < 3000; i++) begin
      int c;
      int r;
      int b;
      bit t;
      c = 50 + int'($urandom % 151);
      r = int'($urandom % (N * c + 1));
      b = int'($urandom % 2001);
      t = ($urandom % 5) != 0;
      drive(t, r, c, b);
      if (i == 1500) do_reset();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule